// File: doc/BRIEF.md
# DMA Interrupt Control and Channel Start Gating

This block holds the interrupt control register of a seven-channel DMA engine, the priority-control register that enables each channel, and one control register per channel. Software reaches all of them through a simple 32-bit register port. The port accepts a write in every cycle it is offered and returns read data combinationally for the current address. It never stalls and has no back-pressure, so it carries no valid/ready handshake.

Each channel reports the end of a transfer with a one-cycle completion pulse. The block records that event as a per-channel flag if the channel's interrupt enable is set. Software clears a flag by writing a 1 to it. From the enables, the flags, a global enable and a force/bus-error bit, the block computes a master interrupt condition every cycle and shows it in the top bit of the register. It emits a single-cycle request to the system interrupt controller only when that condition goes from false to true. A write to a channel's control register with the start bit set produces a one-cycle start strobe for that channel, but only if the priority-control register enables the channel.

Top module: `dma_irq_ctrl`

## Requirements
- R1: After reset the interrupt control register (offset 0xF4) reads 0, the priority-control register (offset 0xF0) reads 0x07654321, every channel control register reads 0, and `sys_irq` and `chan_start` are low.
- R2: A write to 0xF4 loads bits 0-5, bit 15 and bits 16-23 directly from the written value (mask 0x00FF803F); bits 6-14 always read 0.
- R3: Bits 24+n (n = 0..6) are the channel flags. Writing 1 to a flag bit clears it, and writing 0 leaves it unchanged.
- R4: A pulse on `chan_done[n]` sets flag bit 24+n only when enable bit 16+n is set (the value in force after any write in the same cycle). Otherwise the pulse is ignored.
- R5: When a completion pulse and a write-1-to-clear hit the same flag in the same cycle, the flag ends set.
- R6: Bit 31 equals the master condition, which is (bit 23 AND any of bits 24-30) OR bit 15. It is recomputed every cycle and clears as soon as the condition is false.
- R7: `sys_irq` is high for exactly one cycle, the first cycle in which bit 31 reads 1 after it read 0. It is not repeated while bit 31 stays 1.
- R8: A cycle with `bus_err` high sets bit 15. The bit stays set until software writes 0 to it.
- R9: The priority-control register at 0xF0 stores all 32 written bits and reads them back.
- R10: A write to the channel n control register (offset 0x88 + 0x10*n) stores the value. `chan_start[n]` is high in the following cycle if and only if bit 24 of the written value and bit 3+4n of the priority-control register are both set.
- R11: A write to any other offset changes no register and raises no strobe, and such an offset reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe, one write per cycle |
| reg_addr | input | AW (8) | Byte offset of the register accessed |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| chan_done | input | NUM_CH (7) | Per-channel completion pulses |
| bus_err | input | 1 | Bus error indication, sets the force bit |
| chan_start | output | NUM_CH (7) | One-cycle channel start strobes |
| sys_irq | output | 1 | One-cycle request to set the DMA bit of the system interrupt controller |

## Verification
The bench goes after the places where write data and event inputs meet in the same cycle. A completion pulse arriving together with a clear must leave the flag set; a design that gives the clear priority would lose the event. The bench drives pulses on channels whose enable is off, and flags that are set while the global enable is off. A design that ignored the per-channel enable, or that looked only at the flags, would raise bit 31 and `sys_irq` when it should not. It also holds the master condition true across several updates. An edge detector that watches the wrong signal would then repeat the system request or miss it. Start strobes are tried on the first and last channel and on a disabled channel, with and without the start bit, which catches an off-by-one in the enable bit position.

// File: rtl/dma_irq_pkg.sv
`timescale 1ns/1ps
package dma_irq_pkg;
  localparam int unsigned DW           = 32;
  localparam int unsigned OFS_ICR      = 32'hF4;
  localparam int unsigned OFS_PCR      = 32'hF0;
  localparam int unsigned OFS_CTRL0    = 32'h88;
  localparam int unsigned CTRL_STRIDE  = 32'h10;

  localparam int FORCE_BIT   = 15;
  localparam int ENA_LSB     = 16;
  localparam int GLOBAL_BIT  = 23;
  localparam int FLAG_LSB    = 24;
  localparam int MASTER_BIT  = 31;
  localparam int START_BIT   = 24;
  localparam int PCR_EN_BASE = 3;
  localparam int PCR_EN_STEP = 4;

  localparam logic [DW-1:0] DIRECT_MASK = 32'h00FF_803F;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_ICR  = 2'd1,
    SEL_PCR  = 2'd2,
    SEL_CTRL = 2'd3
  } reg_sel_e;

  function automatic int unsigned ctrl_ofs(input int unsigned ch);
    return OFS_CTRL0 + CTRL_STRIDE * ch;
  endfunction
endpackage

// File: rtl/dma_reg_decode.sv
`timescale 1ns/1ps
module dma_reg_decode
  import dma_irq_pkg::*;
#(
  parameter int NUM_CH = 7,
  parameter int AW     = 8
) (
  input  logic [AW-1:0]     addr,
  output reg_sel_e          sel,
  output logic [NUM_CH-1:0] ch_hit
);
  for (genvar n = 0; n < NUM_CH; n++) begin : g_hit
    localparam logic [AW-1:0] CH_OFS = AW'(ctrl_ofs(n));
    assign ch_hit[n] = (addr == CH_OFS);
  end

  always_comb begin
    if (addr == AW'(OFS_ICR))      sel = SEL_ICR;
    else if (addr == AW'(OFS_PCR)) sel = SEL_PCR;
    else if (|ch_hit)              sel = SEL_CTRL;
    else                           sel = SEL_NONE;
  end
endmodule

// File: rtl/dma_irq_flags.sv
`timescale 1ns/1ps
module dma_irq_flags
  import dma_irq_pkg::*;
#(
  parameter int NUM_CH = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_icr,
  input  logic [DW-1:0]     wdata,
  input  logic [NUM_CH-1:0] chan_done,
  input  logic              bus_err,
  output logic [DW-1:0]     icr_q,
  output logic              irq_pulse
);
  logic [DW-1:0]     fields_d;
  logic [NUM_CH-1:0] flags_d;
  logic [NUM_CH-1:0] enables_d;
  logic              master_d;
  logic [DW-1:0]     icr_d;

  // Writable fields come from the bus on a write, else held; the error
  // input can only set the force bit.
  always_comb begin
    fields_d = (wr_icr ? wdata : icr_q) & DIRECT_MASK;
    if (bus_err) fields_d[FORCE_BIT] = 1'b1;
    enables_d = fields_d[ENA_LSB +: NUM_CH];
  end

  // Clear by writing 1, then merge new events so a same-cycle event wins.
  always_comb begin
    flags_d = icr_q[FLAG_LSB +: NUM_CH];
    if (wr_icr) flags_d = flags_d & ~wdata[FLAG_LSB +: NUM_CH];
    flags_d = flags_d | (chan_done & enables_d);
  end

  always_comb begin
    master_d = (fields_d[GLOBAL_BIT] && (|flags_d)) || fields_d[FORCE_BIT];
    icr_d = fields_d;
    icr_d[FLAG_LSB +: NUM_CH] = flags_d;
    icr_d[MASTER_BIT] = master_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      icr_q     <= '0;
      irq_pulse <= 1'b0;
    end else begin
      icr_q     <= icr_d;
      irq_pulse <= master_d && !icr_q[MASTER_BIT];
    end
  end
endmodule

// File: rtl/dma_chan_ctrl.sv
`timescale 1ns/1ps
module dma_chan_ctrl
  import dma_irq_pkg::*;
#(
  parameter int NUM_CH = 7
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_ctrl,
  input  logic [NUM_CH-1:0]        ch_hit,
  input  logic [DW-1:0]            wdata,
  input  logic [DW-1:0]            pcr_q,
  output logic [NUM_CH-1:0][DW-1:0] ctrl_q,
  output logic [NUM_CH-1:0]        start_q
);
  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    localparam int EN_POS = PCR_EN_BASE + PCR_EN_STEP * n;
    logic hit_wr;
    assign hit_wr = wr_ctrl && ch_hit[n];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ctrl_q[n]  <= '0;
        start_q[n] <= 1'b0;
      end else begin
        if (hit_wr) ctrl_q[n] <= wdata;
        start_q[n] <= hit_wr && wdata[START_BIT] && pcr_q[EN_POS];
      end
    end
  end
endmodule

// File: rtl/dma_irq_ctrl.sv
`timescale 1ns/1ps
module dma_irq_ctrl
  import dma_irq_pkg::*;
#(
  parameter int             NUM_CH    = 7,
  parameter int             AW        = 8,
  parameter logic [31:0]    PCR_RESET = 32'h0765_4321
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [AW-1:0]     reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [NUM_CH-1:0] chan_done,
  input  logic              bus_err,
  output logic [NUM_CH-1:0] chan_start,
  output logic              sys_irq
);
  reg_sel_e                 sel;
  logic [NUM_CH-1:0]        ch_hit;
  logic [DW-1:0]            icr_q;
  logic [DW-1:0]            pcr_q;
  logic [NUM_CH-1:0][DW-1:0] ctrl_q;
  logic                     wr_icr, wr_pcr, wr_ctrl;

  dma_reg_decode #(.NUM_CH(NUM_CH), .AW(AW)) u_dec (
    .addr   (reg_addr),
    .sel    (sel),
    .ch_hit (ch_hit)
  );

  assign wr_icr  = reg_we && (sel == SEL_ICR);
  assign wr_pcr  = reg_we && (sel == SEL_PCR);
  assign wr_ctrl = reg_we && (sel == SEL_CTRL);

  dma_irq_flags #(.NUM_CH(NUM_CH)) u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_icr    (wr_icr),
    .wdata     (reg_wdata),
    .chan_done (chan_done),
    .bus_err   (bus_err),
    .icr_q     (icr_q),
    .irq_pulse (sys_irq)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pcr_q <= PCR_RESET;
    else if (wr_pcr) pcr_q <= reg_wdata;
  end

  dma_chan_ctrl #(.NUM_CH(NUM_CH)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_ctrl (wr_ctrl),
    .ch_hit  (ch_hit),
    .wdata   (reg_wdata),
    .pcr_q   (pcr_q),
    .ctrl_q  (ctrl_q),
    .start_q (chan_start)
  );

  always_comb begin
    reg_rdata = '0;
    unique case (sel)
      SEL_ICR:  reg_rdata = icr_q;
      SEL_PCR:  reg_rdata = pcr_q;
      SEL_CTRL: begin
        for (int n = 0; n < NUM_CH; n++)
          if (ch_hit[n]) reg_rdata = reg_rdata | ctrl_q[n];
      end
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/dma_irq_ctrl_chk.sv
`timescale 1ns/1ps
module dma_irq_ctrl_chk
  import dma_irq_pkg::*;
#(
  parameter int NUM_CH = 7,
  parameter int AW     = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic [AW-1:0]     reg_addr,
  input logic [31:0]       reg_wdata,
  input logic [NUM_CH-1:0] chan_done,
  input logic              bus_err,
  input logic [NUM_CH-1:0] chan_start,
  input logic              sys_irq,
  input logic [31:0]       icr_q,
  input logic [31:0]       pcr_q
);
  logic icr_wr, pcr_wr;
  assign icr_wr = reg_we && (reg_addr == AW'(OFS_ICR));
  assign pcr_wr = reg_we && (reg_addr == AW'(OFS_PCR));

  p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    icr_q[14:6] == '0);

  p_field_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    icr_wr |=> icr_q[5:0] == $past(reg_wdata[5:0]));

  p_flag_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (icr_wr && chan_done == '0) |=>
      (icr_q[FLAG_LSB +: NUM_CH] & $past(reg_wdata[FLAG_LSB +: NUM_CH])) == '0);

  p_flag_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
    icr_wr |=>
      (icr_q[FLAG_LSB +: NUM_CH] & $past(icr_q[FLAG_LSB +: NUM_CH] & ~reg_wdata[FLAG_LSB +: NUM_CH]))
        == $past(icr_q[FLAG_LSB +: NUM_CH] & ~reg_wdata[FLAG_LSB +: NUM_CH]));

  p_done_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !icr_wr |=>
      (icr_q[FLAG_LSB +: NUM_CH] & $past(chan_done & icr_q[ENA_LSB +: NUM_CH]))
        == $past(chan_done & icr_q[ENA_LSB +: NUM_CH]));

  p_master_r6: assert property (@(posedge clk) disable iff (!rst_n)
    icr_q[MASTER_BIT] == ((icr_q[GLOBAL_BIT] && (|icr_q[FLAG_LSB +: NUM_CH])) || icr_q[FORCE_BIT]));

  p_irq_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sys_irq |-> (icr_q[MASTER_BIT] && !$past(icr_q[MASTER_BIT])));

  p_irq_needed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(icr_q[MASTER_BIT]) |-> sys_irq);

  p_force_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |=> icr_q[FORCE_BIT]);

  p_pcr_store_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pcr_wr |=> pcr_q == $past(reg_wdata));

  for (genvar n = 0; n < NUM_CH; n++) begin : g_start
    localparam logic [AW-1:0] CH_OFS = AW'(ctrl_ofs(n));
    localparam int EN_POS = PCR_EN_BASE + PCR_EN_STEP * n;
    p_start_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == CH_OFS && reg_wdata[START_BIT] && pcr_q[EN_POS]) |=> chan_start[n]);
    p_start_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_we && reg_addr == CH_OFS) |=> !chan_start[n]);
  end
endmodule

bind dma_irq_ctrl dma_irq_ctrl_chk #(.NUM_CH(NUM_CH), .AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .reg_we     (reg_we),
  .reg_addr   (reg_addr),
  .reg_wdata  (reg_wdata),
  .chan_done  (chan_done),
  .bus_err    (bus_err),
  .chan_start (chan_start),
  .sys_irq    (sys_irq),
  .icr_q      (icr_q),
  .pcr_q      (pcr_q)
);

// File: tb/dma_irq_ctrl_test.sv
`timescale 1ns/1ps
module dma_irq_ctrl_test;
  localparam int NCH = 7;
  localparam real HALF = 2.5;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           reg_we = 1'b0;
  logic [7:0]     reg_addr = 8'h00;
  logic [31:0]    reg_wdata = '0;
  logic [31:0]    reg_rdata;
  logic [NCH-1:0] chan_done = '0;
  logic           bus_err = 1'b0;
  logic [NCH-1:0] chan_start;
  logic           sys_irq;

  int checks = 0;
  int fails  = 0;
  bit cmp_on = 1'b0;
  bit ended  = 1'b0;

  always #(HALF) clk = ~clk;

  dma_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .chan_done(chan_done),
    .bus_err(bus_err), .chan_start(chan_start), .sys_irq(sys_irq)
  );

  // Behavioural reference state
  logic [31:0]    m_icr = '0;
  logic [31:0]    m_pcr = 32'h0765_4321;
  logic [31:0]    m_ctrl [NCH];
  logic           m_irq = 1'b0;
  logic [NCH-1:0] m_start = '0;
  initial for (int i = 0; i < NCH; i++) m_ctrl[i] = '0;

  function automatic logic [31:0] m_read(input logic [7:0] a);
    if (a == 8'hF4) return m_icr;
    if (a == 8'hF0) return m_pcr;
    for (int i = 0; i < NCH; i++) if (a == 8'(8'h88 + 8'h10 * i)) return m_ctrl[i];
    return 32'h0;
  endfunction

  function automatic string rd_tag(input logic [7:0] a);
    if (a == 8'hF4) return "R2/R3/R6";
    if (a == 8'hF0) return "R9";
    for (int i = 0; i < NCH; i++) if (a == 8'(8'h88 + 8'h10 * i)) return "R10";
    return "R11";
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_icr = '0; m_pcr = 32'h0765_4321; m_irq = 0; m_start = '0;
      for (int i = 0; i < NCH; i++) m_ctrl[i] = '0;
    end else begin
      logic [31:0] f;
      logic [NCH-1:0] fl;
      logic ms;
      bit wi;
      wi = reg_we && reg_addr == 8'hF4;
      f  = (wi ? reg_wdata : m_icr) & 32'h00FF_803F;
      if (bus_err) f[15] = 1'b1;
      fl = m_icr[30:24];
      if (wi) fl = fl & ~reg_wdata[30:24];
      fl = fl | (chan_done & f[22:16]);
      ms = (f[23] && fl != 0) || f[15];
      m_irq = ms && !m_icr[31];
      m_icr = f | (32'(fl) << 24) | (32'(ms) << 31);
      for (int i = 0; i < NCH; i++) begin
        bit hit;
        hit = reg_we && reg_addr == 8'(8'h88 + 8'h10 * i);
        m_start[i] = hit && reg_wdata[24] && m_pcr[3 + 4 * i];
        if (hit) m_ctrl[i] = reg_wdata;
      end
      if (reg_we && reg_addr == 8'hF0) m_pcr = reg_wdata;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Cycle-by-cycle comparison against the model, away from the edge
  always @(negedge clk) if (cmp_on && !ended) begin
    chk("R7 sys_irq vs model", 32'(sys_irq), 32'(m_irq));
    chk("R10 chan_start vs model", 32'(chan_start), 32'(m_start));
    chk({rd_tag(reg_addr), " rdata vs model"}, reg_rdata, m_read(reg_addr));
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    step(); reg_we = 1; reg_addr = a; reg_wdata = d;
    step(); reg_we = 0;
  endtask

  task automatic done_pulse(input logic [NCH-1:0] m);
    step(); chan_done = m;
    step(); chan_done = '0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    reg_addr = a; #1;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(HALF * 2 * 200000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    cmp_on = 1;
    // R1 reset state
    rd(8'hF4, 32'h0, "R1 icr reset");
    rd(8'hF0, 32'h0765_4321, "R1 pcr reset");
    rd(8'h88, 32'h0, "R1 ctrl reset");
    chk("R1 sys_irq reset", 32'(sys_irq), 0);
    chk("R1 chan_start reset", 32'(chan_start), 0);

    // R2 masked write, force bit drives master
    wr(8'hF4, 32'hFFFF_FFFF);
    chk("R7 irq after force write", 32'(sys_irq), 1);
    rd(8'hF4, 32'h80FF_803F, "R2 masked fields");
    step();
    chk("R7 no repeat while master held", 32'(sys_irq), 0);
    wr(8'hF4, 32'h0);
    rd(8'hF4, 32'h0, "R6 master clears");

    // R4 completion with enable
    wr(8'hF4, 32'h0081_0000);
    rd(8'hF4, 32'h0081_0000, "R6 no flag no master");
    done_pulse(7'h01);
    chk("R7 irq on first flag", 32'(sys_irq), 1);
    rd(8'hF4, 32'h8181_0000, "R4 flag set when enabled");
    done_pulse(7'h02);
    chk("R7 no irq while already set", 32'(sys_irq), 0);
    rd(8'hF4, 32'h8181_0000, "R4 disabled pulse ignored");

    // R3 write-1-to-clear
    wr(8'hF4, 32'h0281_0000);
    rd(8'hF4, 32'h8181_0000, "R3 zero keeps flag");
    wr(8'hF4, 32'h0181_0000);
    rd(8'hF4, 32'h0081_0000, "R3 one clears flag");

    // R5 same-cycle clear and event
    step(); reg_we = 1; reg_addr = 8'hF4; reg_wdata = 32'h0181_0000; chan_done = 7'h01;
    step(); reg_we = 0; chan_done = '0;
    chk("R5 irq on collision", 32'(sys_irq), 1);
    rd(8'hF4, 32'h8181_0000, "R5 event wins over clear");

    // R6 global enable gates flags
    wr(8'hF4, 32'h0102_0000);
    rd(8'hF4, 32'h0002_0000, "R6 cleared and regated");
    done_pulse(7'h02);
    chk("R6 no irq without global", 32'(sys_irq), 0);
    rd(8'hF4, 32'h0202_0000, "R6 flag without master");
    wr(8'hF4, 32'h0082_0000);
    chk("R6 irq when global set", 32'(sys_irq), 1);
    rd(8'hF4, 32'h8282_0000, "R6 master with global");
    wr(8'hF4, 32'h0200_0000);
    rd(8'hF4, 32'h0, "R3 clear all");

    // R8 bus error input
    step(); bus_err = 1;
    step(); bus_err = 0;
    chk("R8 irq on bus error", 32'(sys_irq), 1);
    rd(8'hF4, 32'h8000_8000, "R8 force bit set");
    step();
    rd(8'hF4, 32'h8000_8000, "R8 force bit sticky");
    wr(8'hF4, 32'h0);
    rd(8'hF4, 32'h0, "R8 force bit cleared by write");

    // R9 priority control
    wr(8'hF0, 32'h0000_0808);
    rd(8'hF0, 32'h0000_0808, "R9 pcr readback");

    // R10 start gating
    wr(8'h88, 32'h0100_0000);
    chk("R10 ch0 start", 32'(chan_start), 32'h01);
    rd(8'h88, 32'h0100_0000, "R10 ch0 ctrl stored");
    wr(8'h98, 32'h0100_0000);
    chk("R10 ch1 disabled no start", 32'(chan_start), 0);
    wr(8'hA8, 32'h0100_0000);
    chk("R10 ch2 start", 32'(chan_start), 32'h04);
    wr(8'hA8, 32'h00FF_FFFF);
    chk("R10 no start without bit24", 32'(chan_start), 0);
    rd(8'hA8, 32'h00FF_FFFF, "R10 ch2 ctrl stored");
    wr(8'hF0, 32'h0800_0000);
    wr(8'hE8, 32'h0100_0000);
    chk("R10 ch6 start", 32'(chan_start), 32'h40);

    // R11 unmapped offset
    wr(8'h40, 32'hFFFF_FFFF);
    chk("R11 no strobe", 32'(chan_start), 0);
    chk("R11 no irq", 32'(sys_irq), 0);
    rd(8'h40, 32'h0, "R11 unmapped reads zero");
    rd(8'hF4, 32'h0, "R11 icr untouched");
    rd(8'hF0, 32'h0800_0000, "R11 pcr untouched");

    // Mixed traffic checked against the model every cycle
    for (int k = 0; k < 600; k++) begin
      int unsigned r;
      r = $urandom;
      step();
      reg_we = r[0];
      case (r[3:1])
        3'd0, 3'd1, 3'd2: reg_addr = 8'hF4;
        3'd3: reg_addr = 8'hF0;
        3'd4: reg_addr = 8'h40;
        default: reg_addr = 8'(8'h88 + 8'h10 * (r[7:4] % NCH));
      endcase
      reg_wdata = $urandom;
      chan_done = r[14:8];
      bus_err = (r[19:15] == 5'd0);
    end
    step(); reg_we = 0; chan_done = '0; bus_err = 0;
    step(); step();
    finish_run();
  end
endmodule